// File: doc/BRIEF.md
# Two-Bit Privilege State Guard

The block keeps a small machine-state register made of two bits, a problem bit and a hypervisor bit, and turns them into one of three privilege levels: user, supervisor or hypervisor. The pipeline asks it to rule on three kinds of request. The first is a write of new values into the state register. The second is an access to a special register tagged with the level it needs. The third is a memory access that carries the restriction tags of the mapping it hit, plus a flag that says whether the access is an instruction fetch or a data access.

Requests that break the rules come back one cycle later as single-cycle pulses. A blocked write or special-register access raises a program-interrupt request. A mapping violation raises either an instruction or a data storage-exception request. The block does not vector interrupts and does not look up translations. The build parameter `HYP_EN` set to 0 builds a two-level variant with no hypervisor state.

Top module: `priv_state_guard`

## Requirements
- R1: While the problem bit is 1, `privState` reads 0 (user) whatever the hypervisor bit holds.
- R2: With the problem bit at 0, `privState` reads 1 (supervisor) when the hypervisor bit is 0 and 2 (hypervisor) when it is 1.
- R3: Reset puts the block in level 2 when `HYP_EN`=1 and in level 1 when `HYP_EN`=0. All exception outputs are low after reset.
- R4: With `HYP_EN`=0 the hypervisor bit of a write is dropped, level 2 never appears, and the supervisor level meets every privilege requirement.
- R5: A write issued at level 1 or 2 loads `wrProb`/`wrHyp`, and the new level shows on the cycle after the request.
- R6: A write issued at level 0 leaves the state unchanged, including an attempt to clear the problem bit, and `progIrq` pulses on the next cycle.
- R7: A special-register access raises `progIrq` on the next cycle when `sprNeed` is above the current rank. The ranks are user 0, supervisor 1 (2 when `HYP_EN`=0) and hypervisor 2. Code 0 never traps and code 3 always traps.
- R8: A memory access tagged `memNeedSup` faults at level 0. One tagged `memNeedHyp` faults below rank 2. A fault pulses `instStorageExc` when `memIsInstr`=1 and `dataStorageExc` otherwise.
- R9: Every exception output is a one-cycle pulse per request, and it is low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | State-register write request |
| wrProb | input | 1 | New problem bit |
| wrHyp | input | 1 | New hypervisor bit |
| sprValid | input | 1 | Special-register access request |
| sprNeed | input | 2 | Required level: 0 none, 1 supervisor, 2 hypervisor, 3 never allowed |
| memValid | input | 1 | Memory access request |
| memIsInstr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| memNeedSup | input | 1 | Mapping denies the user level |
| memNeedHyp | input | 1 | Mapping needs rank 2 |
| privState | output | 2 | Current level: 0 user, 1 supervisor, 2 hypervisor |
| progIrq | output | 1 | Program-interrupt request pulse |
| instStorageExc | output | 1 | Instruction storage-exception pulse |
| dataStorageExc | output | 1 | Data storage-exception pulse |

## Verification
The properties assume that every request is valid for exactly one cycle and is judged against the level held before that cycle's edge. They also assume the request inputs carry known values whenever reset is released. The stimulus drives each request for a single cycle at the falling edge and returns every valid line to 0 afterwards. It includes idle cycles, so that a pulse cannot merge with the next one. Combined requests, such as a write together with a special-register access, are issued only in the user level, where both must trap.

// File: rtl/privguard_pkg.sv
package privguard_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_HYPER = 2'd2
  } privLevel_t;

  typedef struct packed {
    logic loadState;
    logic progTrap;
    logic instFault;
    logic dataFault;
  } guardStrobes_t;
endpackage

// File: rtl/privguard_ctrl.sv
module privguard_ctrl
  import privguard_pkg::*;
#(
  parameter int HYP_EN = 1
) (
  input  privLevel_t    curLevel,
  input  logic          wrValid,
  input  logic          sprValid,
  input  logic [1:0]    sprNeed,
  input  logic          memValid,
  input  logic          memIsInstr,
  input  logic          memNeedSup,
  input  logic          memNeedHyp,
  output guardStrobes_t strobes
);
  localparam logic [1:0] TOP_RANK = 2'd2;

  logic [1:0] rank;
  logic       isUser;
  logic       wrTrap;
  logic       sprTrap;
  logic       memViol;

  // The supervisor rank depends on whether a level exists above it.
  generate
    if (HYP_EN != 0) begin : g_threeLevel
      always_comb begin
        unique case (curLevel)
          LVL_SUPER: rank = 2'd1;
          LVL_HYPER: rank = TOP_RANK;
          default:   rank = 2'd0;
        endcase
      end
    end else begin : g_twoLevel
      always_comb begin
        rank = (curLevel == LVL_USER) ? 2'd0 : TOP_RANK;
      end
    end
  endgenerate

  always_comb begin
    isUser  = (curLevel == LVL_USER);
    wrTrap  = wrValid && isUser;
    sprTrap = sprValid && (sprNeed > rank);
    memViol = memValid && ((memNeedSup && isUser) || (memNeedHyp && (rank != TOP_RANK)));

    strobes.loadState = wrValid && !isUser;
    strobes.progTrap  = wrTrap || sprTrap;
    strobes.instFault = memViol && memIsInstr;
    strobes.dataFault = memViol && !memIsInstr;
  end
endmodule

// File: rtl/privguard_dpath.sv
module privguard_dpath
  import privguard_pkg::*;
#(
  parameter int HYP_EN = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  input  logic          wrProb,
  input  logic          wrHyp,
  output privLevel_t    level,
  output logic          progIrq,
  output logic          instExc,
  output logic          dataExc
);
  localparam logic RST_HYP = (HYP_EN != 0);

  logic probQ;
  logic hypQ;
  logic hypD;

  generate
    if (HYP_EN != 0) begin : g_keepHyp
      assign hypD = wrHyp;
    end else begin : g_dropHyp
      assign hypD = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      probQ   <= 1'b0;
      hypQ    <= RST_HYP;
      progIrq <= 1'b0;
      instExc <= 1'b0;
      dataExc <= 1'b0;
    end else begin
      if (strobes.loadState) begin
        probQ <= wrProb;
        hypQ  <= hypD;
      end
      progIrq <= strobes.progTrap;
      instExc <= strobes.instFault;
      dataExc <= strobes.dataFault;
    end
  end

  always_comb begin
    if (probQ)     level = LVL_USER;
    else if (hypQ) level = LVL_HYPER;
    else           level = LVL_SUPER;
  end
endmodule

// File: rtl/priv_state_guard.sv
module priv_state_guard
  import privguard_pkg::*;
#(
  parameter int HYP_EN = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       wrProb,
  input  logic       wrHyp,
  input  logic       sprValid,
  input  logic [1:0] sprNeed,
  input  logic       memValid,
  input  logic       memIsInstr,
  input  logic       memNeedSup,
  input  logic       memNeedHyp,
  output logic [1:0] privState,
  output logic       progIrq,
  output logic       instStorageExc,
  output logic       dataStorageExc
);
  privLevel_t    curLevel;
  guardStrobes_t strobes;

  privguard_ctrl #(.HYP_EN(HYP_EN)) uCtrl (
    .curLevel   (curLevel),
    .wrValid    (wrValid),
    .sprValid   (sprValid),
    .sprNeed    (sprNeed),
    .memValid   (memValid),
    .memIsInstr (memIsInstr),
    .memNeedSup (memNeedSup),
    .memNeedHyp (memNeedHyp),
    .strobes    (strobes)
  );

  privguard_dpath #(.HYP_EN(HYP_EN)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrProb  (wrProb),
    .wrHyp   (wrHyp),
    .level   (curLevel),
    .progIrq (progIrq),
    .instExc (instStorageExc),
    .dataExc (dataStorageExc)
  );

  assign privState = curLevel;
endmodule

// File: rtl/privguard_chk.sv
module privguard_chk #(
  parameter int HYP_EN = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic       sprValid,
  input logic [1:0] sprNeed,
  input logic       memValid,
  input logic       memIsInstr,
  input logic [1:0] privState,
  input logic       progIrq,
  input logic       instStorageExc,
  input logic       dataStorageExc
);
  AST_USER_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && privState == 2'd0) |=> (privState == 2'd0 && progIrq)); // R6

  AST_STATE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(privState) |-> $past(wrValid)); // R5

  AST_USER_SPR_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (sprValid && privState == 2'd0 && sprNeed != 2'd0) |=> progIrq); // R7

  AST_INST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    instStorageExc |-> $past(memValid && memIsInstr)); // R8

  AST_DATA_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    dataStorageExc |-> $past(memValid && !memIsInstr)); // R8

  AST_PROG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    progIrq |-> $past(wrValid || sprValid)); // R9

  AST_NO_HYP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (HYP_EN == 0) |-> (privState != 2'd2)); // R4
endmodule

bind priv_state_guard privguard_chk #(.HYP_EN(HYP_EN)) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .wrValid        (wrValid),
  .sprValid       (sprValid),
  .sprNeed        (sprNeed),
  .memValid       (memValid),
  .memIsInstr     (memIsInstr),
  .privState      (privState),
  .progIrq        (progIrq),
  .instStorageExc (instStorageExc),
  .dataStorageExc (dataStorageExc)
);

// File: tb/tb_priv_state_guard.sv
`timescale 1ns/1ps
module tb_priv_state_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, wrProb = 0, wrHyp = 0, sprValid = 0;
  logic [1:0] sprNeed = 2'd0;
  logic memValid = 0, memIsInstr = 0, memNeedSup = 0, memNeedHyp = 0;
  logic [1:0] stA, stB;
  logic progA, instA, dataA, progB, instB, dataB;

  int checks = 0;
  int fails = 0;
  logic [9:0] expQ[$];
  string tagQ[$];
  logic mpA, mhA, mpB, mhB;

  always #2.5 clk = ~clk;

  priv_state_guard #(.HYP_EN(1)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrProb(wrProb), .wrHyp(wrHyp),
    .sprValid(sprValid), .sprNeed(sprNeed), .memValid(memValid), .memIsInstr(memIsInstr),
    .memNeedSup(memNeedSup), .memNeedHyp(memNeedHyp), .privState(stA), .progIrq(progA),
    .instStorageExc(instA), .dataStorageExc(dataA));

  priv_state_guard #(.HYP_EN(0)) dutNoHyp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrProb(wrProb), .wrHyp(wrHyp),
    .sprValid(sprValid), .sprNeed(sprNeed), .memValid(memValid), .memIsInstr(memIsInstr),
    .memNeedSup(memNeedSup), .memNeedHyp(memNeedHyp), .privState(stB), .progIrq(progB),
    .instStorageExc(instB), .dataStorageExc(dataB));

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic modelStep(input bit hypEn, inout logic p, inout logic h, output logic [4:0] res);
    logic [1:0] rank;
    logic prog, viol;
    rank = p ? 2'd0 : ((h && hypEn) ? 2'd2 : (hypEn ? 2'd1 : 2'd2));
    prog = (wrValid && p) || (sprValid && (sprNeed > rank));
    viol = memValid && ((memNeedSup && p) || (memNeedHyp && rank != 2'd2));
    if (wrValid && !p) begin
      p = wrProb;
      h = wrHyp && hypEn;
    end
    res = {(p ? 2'd0 : (h ? 2'd2 : 2'd1)), prog, viol && memIsInstr, viol && !memIsInstr};
  endtask

  task automatic drive(input logic wv, input logic wp, input logic wh, input logic sv,
                       input logic [1:0] sn, input logic mv, input logic mi,
                       input logic ms, input logic mh, input string tag);
    logic [4:0] rA, rB;
    @(negedge clk);
    wrValid = wv; wrProb = wp; wrHyp = wh; sprValid = sv; sprNeed = sn;
    memValid = mv; memIsInstr = mi; memNeedSup = ms; memNeedHyp = mh;
    modelStep(1'b1, mpA, mhA, rA);
    modelStep(1'b0, mpB, mhB, rB);
    @(posedge clk);
    #1;
    expQ.push_back({rA, rB});
    tagQ.push_back(tag);
    wrValid = 0; sprValid = 0; memValid = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    mpA = 0; mhA = 1; mpB = 0; mhB = 0;
    @(negedge clk);
    check("R3 reset level/outputs", {stA, progA, instA, dataA, stB, progB, instB, dataB},
          {2'd2, 3'b000, 2'd1, 3'b000});
  endtask

  // Scoreboard monitor: compare after each result edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [9:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {stA, progA, instA, dataA, stB, progB, instB, dataB}, e);
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    drive(0,0,0, 1,2'd2, 0,0,0,0, "R7 hyp-level spr at top rank");
    drive(0,0,0, 0,2'd0, 1,0,0,1, "R8 hyp-only data map at top rank");
    drive(1,0,0, 0,2'd0, 0,0,0,0, "R5 R2 write to supervisor");
    drive(0,0,0, 1,2'd2, 0,0,0,0, "R7 R4 hyp spr from supervisor");
    drive(0,0,0, 0,2'd0, 1,1,0,1, "R8 hyp-only fetch from supervisor");
    drive(0,0,0, 0,2'd0, 0,0,0,0, "R9 idle after fault");
    drive(1,0,1, 0,2'd0, 0,0,0,0, "R2 R4 write hyp bit");
    drive(1,1,1, 0,2'd0, 0,0,0,0, "R1 enter user with hyp bit set");
    drive(1,0,0, 0,2'd0, 0,0,0,0, "R6 user clears problem bit");
    drive(0,0,0, 0,2'd0, 0,0,0,0, "R9 idle after trap");
    drive(0,0,0, 1,2'd0, 0,0,0,0, "R7 unrestricted spr in user");
    drive(0,0,0, 1,2'd1, 0,0,0,0, "R7 supervisor spr in user");
    drive(0,0,0, 1,2'd3, 0,0,0,0, "R7 code 3 spr");
    drive(0,0,0, 0,2'd0, 1,0,1,0, "R8 supervisor-only data in user");
    drive(0,0,0, 0,2'd0, 1,1,1,0, "R8 supervisor-only fetch in user");
    drive(0,0,0, 0,2'd0, 1,1,0,0, "R8 unrestricted fetch in user");
    drive(1,0,1, 1,2'd1, 0,0,0,0, "R6 R7 write plus spr in user");
    doReset();
    drive(0,0,0, 1,2'd3, 0,0,0,0, "R7 code 3 at top rank");
    drive(1,1,0, 0,2'd0, 0,0,0,0, "R1 enter user hyp clear");
    drive(0,0,0, 0,2'd0, 1,0,0,1, "R8 hyp-only data in user");
    drive(0,0,0, 0,2'd0, 0,0,0,0, "R9 final idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule